// File: doc/BRIEF.md
# Programmable Interval Timer Interrupt Source

This block is a periodic timer that sits on a simple 32-bit register bus. It counts bus clock cycles and, each time the count runs out, raises a one-cycle interrupt request. Software programs the interrupt's trap number and priority into the timer's own configuration word. The same word also holds the run bit. A reload word sets the interval in bus clock periods, and a count word reads back the live down-counter.

Software reprograms the timer in three steps. It writes zero to the configuration word to stop the timer, writes the new interval, then writes the configuration word again with the run bit set. Setting the run bit loads the counter from the reload word. Each expiry reloads the counter and counting carries on until the run bit is cleared.

A mode input selects how the programmed trap number is mapped onto the interrupt controller's trap space. In the plain mode any 8-bit trap number goes out unchanged. In the restricted mode the top two bits of the trap field are dropped and replaced by `01`, so only traps 64 to 127 can be emitted. The priority, shifted left by two, is then ORed into the trap number.

The counter is a two-state machine:
- `ST_IDLE`: stopped, counter at zero. Transition *start*: the run bit is seen set, so the counter is loaded and the machine moves to `ST_COUNT`.
- `ST_COUNT`: counting down. Transition *expire*: the count is 1, so a pulse is issued and the counter is reloaded, staying in `ST_COUNT`. Transition *tick*: the counter decrements by one. Transition *stop*: the run bit is seen clear, so the counter is zeroed and the machine returns to `ST_IDLE`.

Top module: `pit_irq_source`

## Requirements
- R1: After reset, the configuration, reload and count words all read 0 and `irq_valid` is low.
- R2: The configuration word is at offset 0x00. Bit 26 is the run bit, bits 23:20 are the 4-bit priority and bits 19:12 are the 8-bit trap number. All other bits read as zero, so writing 0xFFFFFFFF reads back 0x04FFF000. The reload word at 0x10 reads back all 32 written bits. Any unmapped offset reads 0.
- R3: The count word at 0x14 reads 0 while the timer is stopped. One clock after the write that sets the run bit, it reads the effective reload value. It then decreases by one per clock.
- R4: The first pulse appears in the clock that follows the enabling write by N+1 cycles, where N is the effective reload value. Pulses then repeat every N cycles, and each pulse lasts exactly one cycle.
- R5: A reload value of 0 behaves as 1, so a pulse is issued on every cycle.
- R6: Writing zero to the configuration word stops the timer. No further pulses occur and the count word reads 0.
- R7: With `map_restricted` = 0, `irq_trap` equals the programmed trap field and `irq_prio` equals the programmed priority field.
- R8: With `map_restricted` = 1, `irq_trap` = {2'b01, trap[5:0]} OR (priority << 2), which always lies in 64..127. `irq_prio` still carries the priority field.
- R9: The sequence stop, new reload, run restarts the period from the new reload value, even when the three writes are on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the timer counts its periods |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| map_restricted | input | 1 | 0 = plain trap mapping, 1 = restricted 64..127 mapping |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_trap | output | 8 | Trap number carried with the request |
| irq_prio | output | 4 | Priority carried with the request |

## Verification
The bench times the first and second pulse after enabling for several reload values, including 0 and 1. A design with an off-by-one in the load or reload path would shift the pulses by a cycle. One that stalled at zero would never fire at all. It checks the restricted mapping with trap fields whose top bits are set and with large priorities. A mapping that kept the high bits or shifted the priority wrongly would emit traps outside 64..127. It also issues back-to-back stop, reload and run writes and checks the new period. It checks for silence after a stop, which catches a design that missed the stop or kept its old count.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int TRAP_W   = 8;
    localparam int PRIO_W   = 4;
    localparam int EN_BIT   = 26;
    localparam int PRIO_LSB = 20;
    localparam int TRAP_LSB = 12;

    localparam logic [ADDR_W-1:0] OFS_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h14;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_t;

    typedef struct packed {
        logic              run;
        logic [PRIO_W-1:0] prio;
        logic [TRAP_W-1:0] trap;
    } cfg_t;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] count_i,
    output logic [DW-1:0] rdata,
    output cfg_t          cfg_o,
    output logic [DW-1:0] reload_o
);
    cfg_t          cfg_q;
    logic [DW-1:0] reload_q;
    logic [DW-1:0] cfg_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_CFG) begin
                cfg_q.run  <= wdata[EN_BIT];
                cfg_q.prio <= wdata[PRIO_LSB +: PRIO_W];
                cfg_q.trap <= wdata[TRAP_LSB +: TRAP_W];
            end
            if (addr == OFS_RELOAD) begin
                reload_q <= wdata;
            end
        end
    end

    always_comb begin
        cfg_word                       = '0;
        cfg_word[EN_BIT]               = cfg_q.run;
        cfg_word[PRIO_LSB +: PRIO_W]   = cfg_q.prio;
        cfg_word[TRAP_LSB +: TRAP_W]   = cfg_q.trap;
    end

    always_comb begin
        unique case (addr)
            OFS_CFG:    rdata = cfg_word;
            OFS_RELOAD: rdata = reload_q;
            OFS_COUNT:  rdata = count_i;
            default:    rdata = '0;
        endcase
    end

    assign cfg_o    = cfg_q;
    assign reload_o = reload_q;

    // R2: a reload write is visible in the next cycle exactly as written
    a_r2_reload_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_RELOAD) |=> (reload_o == $past(wdata)));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [DW-1:0] reload_i,
    output logic [DW-1:0] count_o,
    output logic          irq_valid_o
);
    cnt_state_t    state_q, state_d;
    logic [DW-1:0] count_q, count_d;
    logic [DW-1:0] load_val;
    logic          fire_d;

    assign load_val = (reload_i == '0) ? DW'(1) : reload_i;

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        fire_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_i) begin
                    state_d = ST_COUNT;
                    count_d = load_val;
                end
            end
            ST_COUNT: begin
                if (!run_i) begin
                    state_d = ST_IDLE;
                    count_d = '0;
                end else if (count_q == DW'(1)) begin
                    count_d = load_val;
                    fire_d  = 1'b1;
                end else begin
                    count_d = count_q - DW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                count_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_valid_o <= 1'b0;
        else        irq_valid_o <= fire_d;
    end

    assign count_o = count_q;

    // R4: while counting, the counter never sits at zero
    a_r4_no_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (count_q != '0));

    // R4: a pulse lasts one cycle unless the interval is one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && count_q != DW'(1)) |=> !irq_valid_o);

    // R6: no request while stopped
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !irq_valid_o);

    // R5: a zero reload loads a count of one
    a_r5_zero_as_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && run_i && reload_i == '0) |=> (count_q == DW'(1)));
endmodule

// File: rtl/pit_vector_map.sv
module pit_vector_map
    import pit_pkg::*;
(
    input  logic              restricted_i,
    input  logic [TRAP_W-1:0] trap_i,
    input  logic [PRIO_W-1:0] prio_i,
    output logic [TRAP_W-1:0] trap_o,
    output logic [PRIO_W-1:0] prio_o
);
    localparam int LOW_W = TRAP_W - 2;

    logic [TRAP_W-1:0] folded;

    assign folded = {2'b01, trap_i[LOW_W-1:0]}
                  | {{(TRAP_W-PRIO_W-2){1'b0}}, prio_i, 2'b00};

    assign trap_o = restricted_i ? folded : trap_i;
    assign prio_o = prio_i;
endmodule

// File: rtl/pit_irq_source.sv
module pit_irq_source
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              map_restricted,
    output logic              irq_valid,
    output logic [TRAP_W-1:0] irq_trap,
    output logic [PRIO_W-1:0] irq_prio
);
    cfg_t              cfg;
    logic [DATA_W-1:0] reload;
    logic [DATA_W-1:0] count;

    pit_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .count_i  (count),
        .rdata    (bus_rdata),
        .cfg_o    (cfg),
        .reload_o (reload)
    );

    pit_counter #(.DW(DATA_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (cfg.run),
        .reload_i    (reload),
        .count_o     (count),
        .irq_valid_o (irq_valid)
    );

    pit_vector_map u_map (
        .restricted_i (map_restricted),
        .trap_i       (cfg.trap),
        .prio_i       (cfg.prio),
        .trap_o       (irq_trap),
        .prio_o       (irq_prio)
    );

    // R8: restricted requests stay inside the 64..127 trap window
    a_r8_trap_window: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && map_restricted) |-> (irq_trap[TRAP_W-1:TRAP_W-2] == 2'b01));

    // R6: a stop write silences requests from the second cycle on
    a_r6_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFS_CFG && !bus_wdata[EN_BIT]) |=> ##1 !irq_valid);
endmodule

// File: tb/test_pit_irq_source.sv
module test_pit_irq_source;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr_en;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        map_restricted;
    logic        irq_valid;
    logic [7:0]  irq_trap;
    logic [3:0]  irq_prio;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pit_irq_source i_pit_irq_source (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .map_restricted(map_restricted), .irq_valid(irq_valid),
        .irq_trap(irq_trap), .irq_prio(irq_prio)
    );

    // vector: {restricted, trap[7:0], prio[3:0], reload[7:0]}
    localparam logic [20:0] VEC [6] = '{
        {1'b0, 8'hA5, 4'd3,  8'd5},
        {1'b0, 8'h00, 4'd15, 8'd1},
        {1'b1, 8'hFF, 4'd0,  8'd4},
        {1'b1, 8'h05, 4'd9,  8'd7},
        {1'b1, 8'hC0, 4'd15, 8'd3},
        {1'b0, 8'h80, 4'd7,  8'd0}
    };

    function automatic logic [7:0] exp_trap(logic m, logic [7:0] t, logic [3:0] p);
        if (!m) return t;
        return 8'h40 | (t & 8'h3F) | {2'b00, p, 2'b00};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg_word(logic [7:0] t, logic [3:0] p);
        return (32'd1 << 26) | ({28'd0, p} << 20) | ({24'd0, t} << 12);
    endfunction

    // Called right after the enabling write; checks pulse times, count and fields.
    task automatic watch_pulses(string tag, int eff, logic [7:0] et, logic [3:0] ep);
        int first = -1, second = -1, cnt = 0;
        for (int k = 1; k <= 2*eff + 1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq_valid) begin
                cnt++;
                if (first < 0) begin
                    first = k;
                    check({tag, " R7/R8 trap"}, {24'd0, irq_trap}, {24'd0, et});
                    check({tag, " R7/R8 prio"}, {28'd0, irq_prio}, {28'd0, ep});
                end else if (second < 0) second = k;
            end
        end
        check({tag, " R4 first pulse"}, first, eff + 1);
        check({tag, " R4 second pulse"}, second, 2*eff + 1);
        check({tag, " R4 pulse count"}, cnt, 2);
    endtask

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
        map_restricted = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h00, rd); check("R1 cfg", rd, 32'h0);
        bus_read(8'h10, rd); check("R1 reload", rd, 32'h0);
        bus_read(8'h14, rd); check("R1 count", rd, 32'h0);
        check("R1 irq", {31'd0, irq_valid}, 32'd0);

        // R2 readback, masking, unmapped
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, rd); check("R2 reload readback", rd, 32'h1234_5678);
        bus_write(8'h00, 32'hFBFF_FFFF);
        bus_read(8'h00, rd); check("R2 cfg mask no run", rd, 32'h00FF_F000);
        bus_write(8'h00, 32'h0);
        bus_read(8'h04, rd); check("R2 unmapped", rd, 32'h0);

        // table walk: R4 R5 R7 R8
        foreach (VEC[i]) begin
            logic        m  = VEC[i][20];
            logic [7:0]  t  = VEC[i][19:12];
            logic [3:0]  p  = VEC[i][11:8];
            logic [7:0]  rl = VEC[i][7:0];
            int eff = (rl == 0) ? 1 : int'(rl);
            map_restricted = m;
            bus_write(8'h00, 32'h0);
            bus_write(8'h10, {24'd0, rl});
            bus_write(8'h00, cfg_word(t, p));
            watch_pulses($sformatf("vec%0d%s", i, (rl == 0) ? " R5" : ""),
                         eff, exp_trap(m, t, p), p);
        end

        // R3 count readback
        map_restricted = 1'b0;
        bus_write(8'h00, 32'h0);
        @(negedge clk);
        bus_read(8'h14, rd); check("R3 count stopped", rd, 32'h0);
        bus_write(8'h10, 32'd10);
        bus_write(8'h00, cfg_word(8'h11, 4'd2));
        @(posedge clk); @(negedge clk);
        bus_read(8'h14, rd); check("R3 count loaded", rd, 32'd10);
        @(posedge clk); @(negedge clk);
        bus_read(8'h14, rd); check("R3 count decrements", rd, 32'd9);

        // R6 stop
        bus_write(8'h00, 32'h0);
        begin
            int seen = 0;
            for (int k = 0; k < 30; k++) begin
                @(posedge clk); @(negedge clk);
                if (irq_valid) seen++;
            end
            check("R6 no pulse after stop", seen, 0);
        end
        bus_read(8'h14, rd); check("R6 count zero", rd, 32'h0);

        // R9 back-to-back reprogramming while running
        bus_write(8'h10, 32'd6);
        bus_write(8'h00, cfg_word(8'h22, 4'd1));
        repeat (4) @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
        @(negedge clk);
        bus_addr = 8'h10; bus_wdata = 32'd3;
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = cfg_word(8'h33, 4'd4);
        @(posedge clk);
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
        // enable seen one cycle after its write edge, stop handled first
        begin
            int first = -1;
            for (int k = 1; k <= 12; k++) begin
                @(posedge clk); @(negedge clk);
                if (irq_valid && first < 0) begin
                    first = k;
                    check("R9 trap after reprogram", {24'd0, irq_trap}, 32'h33);
                end
            end
            check("R9 new period first pulse", first, 4);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule